// File: doc/BRIEF.md
# SPD Checksum and Timing Extractor

This block sits between the serial fetch logic of a memory controller and the controller's timing registers. The fetch logic hands over the presence-detect image of a memory module one byte at a time, each byte tagged with its index. The block collects the 64 checksummed bytes in whatever order they arrive and keeps only the first copy of each. Once all 64 are present it works out the fields the controller needs.

Those fields are the address geometry, the bank count and the burst-length support. The block also computes a CAS latency usable at the controller's clock period, and turns the four nanosecond row timings into whole clock cycles. It also reports whether the stored checksum matches, whether the module is of the supported type, and whether no CAS latency works at the given clock.

The clock period comes in on an input, in tenths of a nanosecond. Each nanosecond-to-cycle conversion is a ceiling division done by repeated subtraction, one subtraction per cycle. The four conversions run one after another before the done flag rises.

Top module: `spd_timing_decode`

## Requirements
- R1: `done` stays low until every index 0 to 63 has been accepted at least once, rises after the conversions finish, and then stays high until reset. Indices 64 and above are ignored.
- R2: `csum_err` is high after done exactly when the index-63 byte differs from the low 8 bits of the sum of the bytes at indices 0 to 62.
- R3: `type_err` is high after done exactly when the index-2 byte is not 0x04.
- R4: After done, the outputs carry these bytes:
  - `row_bits` is bits [4:0] of byte 3.
  - `col_bits` is bits [4:0] of byte 4.
  - `bank_count` is byte 17.
- R5: After done, `bl_mask` is bits [3:0] of byte 16. Bit 0 flags length 1, bit 1 length 2, bit 2 length 4 and bit 3 length 8.
- R6: After done, each timing output is ceil(ns × 10 / `tck_tenths`), saturating at 255, and 0 when ns is 0. The ns values are taken from these bytes:
  - `t_rp` from byte 27.
  - `t_rrd` from byte 28.
  - `t_rcd` from byte 29.
  - `t_ras` from byte 30.
- R7: A minimum-cycle byte (9 or 23) is read as high nibble × 10 + low nibble, in tenths of a nanosecond.
- R8: CAS-latency choice works as follows:
  - Bit n (0 to 6) of byte 18 set means latency n+1 is supported.
  - The highest set bit uses byte 9 as its minimum cycle; the next set bit below it uses byte 23.
  - If the lower one exists and its minimum is no greater than `tck_tenths`, `cas_lat` is that latency.
  - Otherwise, if the highest latency's minimum fits, `cas_lat` is the highest latency.
  - Otherwise `cl_err` is high and `cas_lat` is 0.
- R9: A second arrival of an already accepted index has no effect on any result.
- R10: While `done` is low, every other output is 0. After done, outputs do not change until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte strobe |
| in_idx | input | 7 | Byte index within the image |
| in_byte | input | 8 | Byte value |
| tck_tenths | input | 8 | Controller clock period in 0.1 ns |
| done | output | 1 | Results valid |
| csum_err | output | 1 | Checksum mismatch |
| type_err | output | 1 | Module type not supported |
| cl_err | output | 1 | No CAS latency fits the clock |
| row_bits | output | 5 | Row address bits |
| col_bits | output | 5 | Column address bits |
| bank_count | output | 8 | Internal bank count |
| bl_mask | output | 4 | Supported burst lengths 1/2/4/8 |
| cas_lat | output | 3 | Chosen CAS latency |
| t_rp | output | 8 | Precharge time in cycles |
| t_rrd | output | 8 | Row-to-row delay in cycles |
| t_rcd | output | 8 | Row-to-column delay in cycles |
| t_ras | output | 8 | Minimum active time in cycles |

## Verification
Filling the last empty slot of the seen map and taking a byte into the checksum path can happen in the same cycle. That byte is either the final term of the running sum or the stored checksum itself. The bench shuffles every image so this final index falls on a random position: sometimes byte 63, sometimes a decoded field, sometimes an ordinary summed byte. It also interleaves stale repeats and out-of-range indices. `csum_err` and the decoded fields are then judged against a sum and decode computed by the bench from the first copy of each byte.

// File: rtl/spd_pkg.sv
`timescale 1ns/1ps
package spd_pkg;

    localparam int CHK_BYTES = 64;
    localparam logic [7:0] MEM_SDR = 8'h04;

    // byte positions that carry meaning
    localparam int POS_TYPE  = 2;
    localparam int POS_ROWS  = 3;
    localparam int POS_COLS  = 4;
    localparam int POS_TTOP  = 9;
    localparam int POS_BL    = 16;
    localparam int POS_BANKS = 17;
    localparam int POS_CL    = 18;
    localparam int POS_TNXT  = 23;
    localparam int POS_RP    = 27;
    localparam int POS_RRD   = 28;
    localparam int POS_RCD   = 29;
    localparam int POS_RAS   = 30;

    typedef struct packed {
        logic [7:0] mem_type;
        logic [7:0] rows;
        logic [7:0] cols;
        logic [7:0] tmin_top;
        logic [7:0] bl;
        logic [7:0] banks;
        logic [7:0] cl_mask;
        logic [7:0] tmin_nxt;
        logic [7:0] rp;
        logic [7:0] rrd;
        logic [7:0] rcd;
        logic [7:0] ras;
    } spd_fields_t;

    typedef struct packed {
        logic       err;
        logic [2:0] cl;
    } cl_pick_t;

    typedef enum logic [1:0] {
        ST_COLLECT,
        ST_LOAD,
        ST_WAIT,
        ST_DONE
    } seq_state_t;

    function automatic logic [7:0] nibble_tenths(input logic [7:0] b);
        return 8'(b[7:4] * 4'd10) + 8'(b[3:0]);
    endfunction

    function automatic cl_pick_t pick_cl(input logic [7:0] mask,
                                         input logic [7:0] t_top,
                                         input logic [7:0] t_nxt,
                                         input logic [7:0] tck);
        cl_pick_t   r;
        logic       has_top;
        logic       has_nxt;
        logic [2:0] top;
        logic [2:0] nxt;
        has_top = 1'b0;
        has_nxt = 1'b0;
        top     = 3'd0;
        nxt     = 3'd0;
        for (int b = 6; b >= 0; b--) begin
            if (mask[b]) begin
                if (!has_top) begin
                    has_top = 1'b1;
                    top     = 3'(b);
                end else if (!has_nxt) begin
                    has_nxt = 1'b1;
                    nxt     = 3'(b);
                end
            end
        end
        r.err = 1'b1;
        r.cl  = 3'd0;
        if (has_nxt && nibble_tenths(t_nxt) <= tck) begin
            r.err = 1'b0;
            r.cl  = nxt + 3'd1;
        end else if (has_top && nibble_tenths(t_top) <= tck) begin
            r.err = 1'b0;
            r.cl  = top + 3'd1;
        end
        return r;
    endfunction

endpackage

// File: rtl/spd_capture.sv
`timescale 1ns/1ps
module spd_capture
    import spd_pkg::*;
#(
    parameter int IDX_W = 7,
    parameter int NBYTE = spd_pkg::CHK_BYTES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [IDX_W-1:0] in_idx,
    input  logic [7:0]       in_byte,
    output logic             all_seen,
    output logic             sum_ok,
    output spd_fields_t      fields
);
    localparam int SLOT_W = $clog2(NBYTE);

    logic [NBYTE-1:0]  seen;
    logic [7:0]        sum;
    logic [7:0]        csum_rx;
    logic [SLOT_W-1:0] slot;
    logic              in_range;
    logic              accept;

    assign slot     = in_idx[SLOT_W-1:0];
    assign in_range = (in_idx < IDX_W'(NBYTE));
    assign accept   = in_valid && in_range && !seen[slot];

    always_ff @(posedge clk) begin
        if (rst) begin
            seen    <= '0;
            sum     <= '0;
            csum_rx <= '0;
            fields  <= '0;
        end else if (accept) begin
            seen[slot] <= 1'b1;
            if (slot == SLOT_W'(NBYTE - 1)) begin
                csum_rx <= in_byte;
            end else begin
                sum <= sum + in_byte;
            end
            case (int'(slot))
                POS_TYPE:  fields.mem_type <= in_byte;
                POS_ROWS:  fields.rows     <= in_byte;
                POS_COLS:  fields.cols     <= in_byte;
                POS_TTOP:  fields.tmin_top <= in_byte;
                POS_BL:    fields.bl       <= in_byte;
                POS_BANKS: fields.banks    <= in_byte;
                POS_CL:    fields.cl_mask  <= in_byte;
                POS_TNXT:  fields.tmin_nxt <= in_byte;
                POS_RP:    fields.rp       <= in_byte;
                POS_RRD:   fields.rrd      <= in_byte;
                POS_RCD:   fields.rcd      <= in_byte;
                POS_RAS:   fields.ras      <= in_byte;
                default: ;
            endcase
        end
    end

    assign all_seen = &seen;
    assign sum_ok   = (sum == csum_rx);

endmodule

// File: rtl/spd_ceil_div.sv
`timescale 1ns/1ps
module spd_ceil_div #(
    parameter int NUM_W = 12,
    parameter int DEN_W = 8,
    parameter int Q_W   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             busy,
    output logic [Q_W-1:0]   quot
);
    logic [NUM_W-1:0] rem;
    logic [NUM_W-1:0] den_x;

    assign den_x = NUM_W'(den);
    assign busy  = (rem != '0) && (quot != '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            rem  <= '0;
            quot <= '0;
        end else if (start) begin
            rem  <= num;
            quot <= '0;
        end else if (busy) begin
            quot <= quot + 1'b1;
            rem  <= (rem > den_x) ? rem - den_x : '0;
        end
    end

endmodule

// File: rtl/spd_timing_decode.sv
`timescale 1ns/1ps
module spd_timing_decode
    import spd_pkg::*;
#(
    parameter int IDX_W = 7,
    parameter int CYC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [IDX_W-1:0] in_idx,
    input  logic [7:0]       in_byte,
    input  logic [7:0]       tck_tenths,
    output logic             done,
    output logic             csum_err,
    output logic             type_err,
    output logic             cl_err,
    output logic [4:0]       row_bits,
    output logic [4:0]       col_bits,
    output logic [7:0]       bank_count,
    output logic [3:0]       bl_mask,
    output logic [2:0]       cas_lat,
    output logic [CYC_W-1:0] t_rp,
    output logic [CYC_W-1:0] t_rrd,
    output logic [CYC_W-1:0] t_rcd,
    output logic [CYC_W-1:0] t_ras
);
    localparam int NUM_T = 4;
    localparam int NUM_W = 8 + 4;
    localparam int SEL_W = $clog2(NUM_T);

    spd_fields_t      fld;
    logic             all_seen;
    logic             sum_ok;
    logic [7:0]       cap_cl_mask;
    seq_state_t       state;
    logic [SEL_W-1:0] sel;
    logic [7:0]       ns_sel;
    logic [NUM_W-1:0] num;
    logic             div_start;
    logic             div_busy;
    logic [CYC_W-1:0] div_q;
    logic [CYC_W-1:0] cyc [NUM_T];
    logic             done_r;
    logic             csum_err_r;
    logic             type_err_r;
    cl_pick_t         pick;
    cl_pick_t         pick_r;

    spd_capture #(.IDX_W(IDX_W), .NBYTE(CHK_BYTES)) cap_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_idx(in_idx),
        .in_byte(in_byte), .all_seen(all_seen), .sum_ok(sum_ok), .fields(fld)
    );

    assign cap_cl_mask = fld.cl_mask;

    always_comb begin
        case (sel)
            2'd0:    ns_sel = fld.rp;
            2'd1:    ns_sel = fld.rrd;
            2'd2:    ns_sel = fld.rcd;
            default: ns_sel = fld.ras;
        endcase
    end

    assign num       = NUM_W'(ns_sel) * NUM_W'(10);
    assign div_start = (state == ST_LOAD);

    spd_ceil_div #(.NUM_W(NUM_W), .DEN_W(8), .Q_W(CYC_W)) div_i (
        .clk(clk), .rst(rst), .start(div_start), .num(num),
        .den(tck_tenths), .busy(div_busy), .quot(div_q)
    );

    assign pick = pick_cl(fld.cl_mask, fld.tmin_top, fld.tmin_nxt, tck_tenths);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_COLLECT;
            sel        <= '0;
            done_r     <= 1'b0;
            csum_err_r <= 1'b0;
            type_err_r <= 1'b0;
            pick_r     <= '0;
            for (int i = 0; i < NUM_T; i++) cyc[i] <= '0;
        end else begin
            case (state)
                ST_COLLECT: if (all_seen) state <= ST_LOAD;
                ST_LOAD:    state <= ST_WAIT;
                ST_WAIT: begin
                    if (!div_busy) begin
                        cyc[sel] <= div_q;
                        if (sel == SEL_W'(NUM_T - 1)) begin
                            state      <= ST_DONE;
                            done_r     <= 1'b1;
                            csum_err_r <= !sum_ok;
                            type_err_r <= (fld.mem_type != MEM_SDR);
                            pick_r     <= pick;
                        end else begin
                            sel   <= sel + 1'b1;
                            state <= ST_LOAD;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign done       = done_r;
    assign csum_err   = csum_err_r;
    assign type_err   = type_err_r;
    assign cl_err     = pick_r.err;
    assign cas_lat    = pick_r.cl;
    assign row_bits   = done_r ? fld.rows[4:0] : '0;
    assign col_bits   = done_r ? fld.cols[4:0] : '0;
    assign bank_count = done_r ? fld.banks     : '0;
    assign bl_mask    = done_r ? fld.bl[3:0]   : '0;
    assign t_rp       = done_r ? cyc[0] : '0;
    assign t_rrd      = done_r ? cyc[1] : '0;
    assign t_rcd      = done_r ? cyc[2] : '0;
    assign t_ras      = done_r ? cyc[3] : '0;

endmodule

// File: rtl/spd_timing_decode_chk.sv
`timescale 1ns/1ps
module spd_timing_decode_chk (
    input logic       clk,
    input logic       rst,
    input logic       done,
    input logic       csum_err,
    input logic       type_err,
    input logic       cl_err,
    input logic [2:0] cas_lat,
    input logic [7:0] t_ras,
    input logic       all_seen,
    input logic [7:0] cl_mask
);
    assert_done_after_all_R1: assert property (@(posedge clk) disable iff (rst)
        done |-> all_seen);

    assert_done_sticky_R1: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    assert_flags_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !done |-> (!csum_err && !type_err && !cl_err && cas_lat == 3'd0));

    assert_results_stable_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> ($stable(t_ras) && $stable(cas_lat) && $stable(csum_err)));

    assert_cl_in_mask_R8: assert property (@(posedge clk) disable iff (rst)
        (done && !cl_err) |-> (cas_lat != 3'd0 && cl_mask[cas_lat - 3'd1]));

    assert_cl_err_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (done && cl_err) |-> (cas_lat == 3'd0));
endmodule

bind spd_timing_decode spd_timing_decode_chk chk_i (
    .clk(clk), .rst(rst), .done(done), .csum_err(csum_err),
    .type_err(type_err), .cl_err(cl_err), .cas_lat(cas_lat),
    .t_ras(t_ras), .all_seen(all_seen), .cl_mask(cap_cl_mask)
);

// File: tb/spd_timing_decode_tb_top.sv
`timescale 1ns/1ps
module spd_timing_decode_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [6:0] in_idx = '0;
    logic [7:0] in_byte = '0;
    logic [7:0] tck_tenths = 8'd75;
    logic       done, csum_err, type_err, cl_err;
    logic [4:0] row_bits, col_bits;
    logic [7:0] bank_count;
    logic [3:0] bl_mask;
    logic [2:0] cas_lat;
    logic [7:0] t_rp, t_rrd, t_rcd, t_ras;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] img [0:63];
    int order [0:63];

    always #4 clk = ~clk;

    spd_timing_decode dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_idx(in_idx),
        .in_byte(in_byte), .tck_tenths(tck_tenths), .done(done),
        .csum_err(csum_err), .type_err(type_err), .cl_err(cl_err),
        .row_bits(row_bits), .col_bits(col_bits), .bank_count(bank_count),
        .bl_mask(bl_mask), .cas_lat(cas_lat), .t_rp(t_rp), .t_rrd(t_rrd),
        .t_rcd(t_rcd), .t_ras(t_ras)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_cyc(input int ns, input int tck);
        int v;
        if (ns == 0) return 0;
        if (tck == 0) return 255;
        v = (ns * 10 + tck - 1) / tck;
        return (v > 255) ? 255 : v;
    endfunction

    function automatic int tenths_of(input logic [7:0] b);  // R7
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    // R8: returns chosen latency, 0 when none fits
    function automatic int exp_cl(input logic [7:0] mask, input int tck);
        int hi, lo;
        hi = 0; lo = 0;
        for (int c = 1; c <= 7; c++) begin
            if (mask[c-1]) begin
                lo = hi;
                hi = c;
            end
        end
        if (lo != 0 && tenths_of(img[23]) <= tck) return lo;
        if (hi != 0 && tenths_of(img[9]) <= tck) return hi;
        return 0;
    endfunction

    function automatic logic [7:0] sum62();
        logic [7:0] s = 8'd0;
        for (int i = 0; i < 63; i++) s = s + img[i];
        return s;
    endfunction

    task automatic base_image();
        for (int i = 0; i < 64; i++) img[i] = 8'($urandom);
        img[2] = 8'h04;  img[3] = 8'h0C; img[4] = 8'h09;
        img[9] = 8'h70;  img[16] = 8'h0F; img[17] = 8'h04;
        img[18] = 8'h06; img[23] = 8'h75;
        img[27] = 8'd15; img[28] = 8'd15; img[29] = 8'd15; img[30] = 8'd45;
        img[63] = sum62();
    endtask

    task automatic send(input int idx, input logic [7:0] val);
        @(negedge clk);
        in_valid = 1'b1;
        in_idx   = 7'(idx);
        in_byte  = val;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_case(input int tck, input bit noise);
        int j, t, waited;
        do_reset();
        tck_tenths = 8'(tck);
        for (int i = 0; i < 64; i++) order[i] = i;
        for (int i = 63; i > 0; i--) begin
            j = int'($urandom % (i + 1));
            t = order[i]; order[i] = order[j]; order[j] = t;
        end
        for (int i = 0; i < 64; i++) begin
            send(order[i], img[order[i]]);
            if (noise) begin
                // R9: stale repeat of an accepted index with a wrong value
                if ($urandom % 3 == 0) begin
                    j = order[$urandom % (i + 1)];
                    send(j, img[j] ^ 8'h5A);
                end
                // R1: out-of-range index must be ignored
                send(64 + int'($urandom % 64), 8'($urandom));
            end
            if (i == 62) begin
                repeat (3) @(negedge clk);
                check("R1 done before all indices", int'(done), 0);
                check("R10 outputs idle before done",
                      int'(t_ras) + int'(cas_lat) + int'(csum_err) + int'(row_bits), 0);
            end
        end
        waited = 0;
        while (!done && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        check("R1 done after all indices", int'(done), 1);
        check("R2 checksum flag", int'(csum_err), int'(sum62() != img[63]));
        check("R3 type flag", int'(type_err), int'(img[2] != 8'h04));
        check("R4 row bits", int'(row_bits), int'(img[3][4:0]));
        check("R4 col bits", int'(col_bits), int'(img[4][4:0]));
        check("R4 banks", int'(bank_count), int'(img[17]));
        check("R5 burst mask", int'(bl_mask), int'(img[16][3:0]));
        check("R6 tRP cycles", int'(t_rp), exp_cyc(int'(img[27]), tck));
        check("R6 tRRD cycles", int'(t_rrd), exp_cyc(int'(img[28]), tck));
        check("R6 tRCD cycles", int'(t_rcd), exp_cyc(int'(img[29]), tck));
        check("R6 tRAS cycles", int'(t_ras), exp_cyc(int'(img[30]), tck));
        check("R8 cas latency", int'(cas_lat), exp_cl(img[18], tck));
        check("R8 cl error", int'(cl_err), int'(exp_cl(img[18], tck) == 0));
        // R10: results hold after done even when the period input moves
        tck_tenths = tck_tenths + 8'd3;
        repeat (4) @(negedge clk);
        check("R10 done held", int'(done), 1);
        check("R10 tRAS held", int'(t_ras), exp_cyc(int'(img[30]), tck));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        do_reset();
        @(negedge clk);
        check("R10 reset done", int'(done), 0);
        check("R10 reset outputs", int'(t_rp) + int'(bank_count) + int'(bl_mask), 0);

        base_image();
        run_case(75, 1'b0);            // R8 lower latency exactly fits, R7
        run_case(70, 1'b0);            // R8 falls back to highest latency
        run_case(69, 1'b0);            // R8 nothing fits
        img[63] = img[63] ^ 8'h01;
        run_case(75, 1'b1);            // R2 mismatch, R9 repeats
        base_image();
        img[2] = 8'h02;
        img[63] = sum62();
        run_case(75, 1'b1);            // R3 wrong type
        base_image();
        img[30] = 8'hFF; img[27] = 8'd0;
        img[63] = sum62();
        run_case(1, 1'b0);             // R6 saturation and zero
        base_image();
        img[18] = 8'h00;
        img[63] = sum62();
        run_case(100, 1'b1);           // R8 empty mask

        for (int k = 0; k < 10; k++) begin
            for (int i = 0; i < 64; i++) img[i] = 8'($urandom);
            if ($urandom % 4 != 0) img[2] = 8'h04;
            img[9]  = {4'(5 + $urandom % 8), 4'($urandom % 10)};
            img[23] = {4'(5 + $urandom % 8), 4'($urandom % 10)};
            img[18] = 8'($urandom) & 8'h7F;
            img[63] = sum62();
            if ($urandom % 5 == 0) img[63] = img[63] + 8'd1;
            run_case(40 + int'($urandom % 120), 1'b1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule